// File: doc/BRIEF.md
# Read-Priority Miss Controller With Victim Buffer

This controller sits between a write-back cache and memory and handles one miss at a time. A clean miss goes straight to memory as a line read. When a miss evicts a dirty line, the controller first parks that line in a one-line writeback buffer. It then performs the memory read and restarts the processor as soon as the fill returns. The parked line goes back to memory only after the restart, and only while no read is waiting to be served.

Reads therefore overtake the pending write. There is one exception: a miss whose address equals the parked line's address is held off until that line has drained to memory. This build waits for the drain and does not forward the buffered data. A second dirty eviction that arrives while the buffer is still occupied is also held off until the drain completes.

The request side uses a valid/ready handshake. Each memory channel uses a request line that is held until its acknowledge. The processor side receives a one-cycle restart pulse that carries the fill line.

Top module: `rd_prio_miss_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_rd_req`, `mem_wr_req` and `cpu_restart` are 0.
- R2: A clean miss (`victim_dirty`=0) accepted on a clock edge raises `mem_rd_req` in the next cycle, with `mem_rd_addr` equal to the accepted `miss_addr`.
- R3: A dirty miss spends exactly one cycle copying the victim into the writeback buffer. `mem_rd_req` rises in the second cycle after acceptance.
- R4: The victim line of a dirty miss is written to memory only after that miss's read has been acknowledged and the processor restarted.
- R5: `cpu_restart` is a single-cycle pulse in the cycle after the read acknowledge. `cpu_fill_data` equals the `mem_rd_data` sampled with that acknowledge.
- R6: A writeback starts only from the idle state when no acceptable miss is presented. A non-conflicting clean miss that arrives while a line is parked is read from memory before the parked line is written.
- R7: While a line is parked, a miss whose `miss_addr` equals the parked address sees `miss_ready`=0 until the writeback acknowledge has emptied the buffer.
- R8: While a line is parked, a miss with `victim_dirty`=1 sees `miss_ready`=0 until the buffer has drained.
- R9: `mem_wr_req` stays high with stable `mem_wr_addr` and `mem_wr_data` until `mem_wr_ack`. The written address and data are the parked victim's. The buffer is empty after the acknowledge.
- R10: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack`.
- R11: `mem_rd_req` and `mem_wr_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss request is presented |
| miss_ready | output | 1 | The presented miss is accepted on this edge |
| miss_addr | input | ADDR_W | Line address that missed |
| victim_dirty | input | 1 | The line being replaced is dirty |
| victim_addr | input | ADDR_W | Line address of the replaced line |
| victim_data | input | LINE_W | Contents of the replaced line |
| mem_rd_req | output | 1 | Line read request to memory |
| mem_rd_addr | output | ADDR_W | Address of the line read |
| mem_rd_ack | input | 1 | Memory returns the read line |
| mem_rd_data | input | LINE_W | Line returned by memory |
| mem_wr_req | output | 1 | Line write request to memory |
| mem_wr_addr | output | ADDR_W | Address of the line write |
| mem_wr_data | output | LINE_W | Line being written back |
| mem_wr_ack | input | 1 | Memory has taken the write |
| cpu_restart | output | 1 | One-cycle pulse: the processor may resume |
| cpu_fill_data | output | LINE_W | Fill line delivered with the restart |

## Verification
A stale or wrong occupancy flag in the writeback buffer shows up at `miss_ready` in the very next cycle in which a dirty or same-address miss is presented. It also appears as a missing or spurious `mem_wr_req` as soon as the controller falls idle. A state machine that takes the wrong path shows as a one-cycle shift of `mem_rd_req` or `cpu_restart` relative to acceptance or acknowledge. A wrong parked address or line shows on `mem_wr_addr` and `mem_wr_data` in the first cycle of the writeback. Comparing every output on every cycle against a behavioural model therefore catches such faults within one or two cycles of their cause.

// File: rtl/rpmc_pkg.sv
package rpmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COPY    = 3'd1,
    ST_READ    = 3'd2,
    ST_RESTART = 3'd3,
    ST_WBACK   = 3'd4
  } mc_state_e;

  // A miss may be taken only when idle and it neither conflicts with the
  // parked line nor needs the buffer that is already occupied.
  function automatic logic accept_ok(input logic idle, input logic full,
                                     input logic hit, input logic dirty);
    return idle && !(full && (hit || dirty));
  endfunction

endpackage

// File: rtl/rpmc_victim_buf.sv
module rpmc_victim_buf #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we,
  input  logic [ADDR_W-1:0] stage_addr,
  input  logic [LINE_W-1:0] stage_data,
  input  logic              commit,
  input  logic              drain,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              full,
  output logic              probe_hit,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [LINE_W-1:0] buf_data
);

  logic [ADDR_W-1:0] stg_addr_q;
  logic [LINE_W-1:0] stg_data_q;

  function automatic logic same_line(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b);
    return a == b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_addr_q <= '0;
      stg_data_q <= '0;
    end else if (stage_we) begin
      stg_addr_q <= stage_addr;
      stg_data_q <= stage_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
    end else if (commit) begin
      full     <= 1'b1;
      buf_addr <= stg_addr_q;
      buf_data <= stg_data_q;
    end else if (drain) begin
      full     <= 1'b0;
    end
  end

  assign probe_hit = full && same_line(probe_addr, buf_addr);

endmodule

// File: rtl/rpmc_read_port.sv
module rpmc_read_port #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              fill_we,
  input  logic [LINE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LINE_W-1:0] fill_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
    end else if (capture) begin
      req_addr <= miss_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_data <= '0;
    end else if (fill_we) begin
      fill_data <= rd_data;
    end
  end

endmodule

// File: rtl/rpmc_fsm.sv
module rpmc_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic victim_dirty,
  input  logic buf_full,
  input  logic probe_hit,
  input  logic mem_rd_ack,
  input  logic mem_wr_ack,
  output logic miss_ready,
  output logic accept,
  output logic copy_en,
  output logic rd_req,
  output logic rd_done,
  output logic restart,
  output logic wr_req,
  output logic wr_done
);
  import rpmc_pkg::*;

  mc_state_e state_q, state_d;

  assign miss_ready = accept_ok(state_q == ST_IDLE, buf_full, probe_hit, victim_dirty);
  assign accept     = miss_valid && miss_ready;
  assign copy_en    = (state_q == ST_COPY);
  assign rd_req     = (state_q == ST_READ);
  assign rd_done    = rd_req && mem_rd_ack;
  assign restart    = (state_q == ST_RESTART);
  assign wr_req     = (state_q == ST_WBACK);
  assign wr_done    = wr_req && mem_wr_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept)        state_d = victim_dirty ? ST_COPY : ST_READ;
        else if (buf_full) state_d = ST_WBACK;
      end
      ST_COPY:    state_d = ST_READ;
      ST_READ:    if (mem_rd_ack) state_d = ST_RESTART;
      ST_RESTART: state_d = ST_IDLE;
      ST_WBACK:   if (mem_wr_ack) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/rd_prio_miss_ctrl.sv
module rd_prio_miss_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              victim_dirty,
  input  logic [ADDR_W-1:0] victim_addr,
  input  logic [LINE_W-1:0] victim_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [LINE_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              cpu_restart,
  output logic [LINE_W-1:0] cpu_fill_data
);

  // Named internal events, visible to the bound checker.
  logic accept_evt;
  logic stage_evt;
  logic copy_evt;
  logic rd_done_evt;
  logic wr_done_evt;
  logic buf_full;
  logic buf_hit;

  assign stage_evt = accept_evt && victim_dirty;

  rpmc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .victim_dirty (victim_dirty),
    .buf_full     (buf_full),
    .probe_hit    (buf_hit),
    .mem_rd_ack   (mem_rd_ack),
    .mem_wr_ack   (mem_wr_ack),
    .miss_ready   (miss_ready),
    .accept       (accept_evt),
    .copy_en      (copy_evt),
    .rd_req       (mem_rd_req),
    .rd_done      (rd_done_evt),
    .restart      (cpu_restart),
    .wr_req       (mem_wr_req),
    .wr_done      (wr_done_evt)
  );

  rpmc_victim_buf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_vbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_we   (stage_evt),
    .stage_addr (victim_addr),
    .stage_data (victim_data),
    .commit     (copy_evt),
    .drain      (wr_done_evt),
    .probe_addr (miss_addr),
    .full       (buf_full),
    .probe_hit  (buf_hit),
    .buf_addr   (mem_wr_addr),
    .buf_data   (mem_wr_data)
  );

  rpmc_read_port #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_rport (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept_evt),
    .miss_addr (miss_addr),
    .fill_we   (rd_done_evt),
    .rd_data   (mem_rd_data),
    .req_addr  (mem_rd_addr),
    .fill_data (cpu_fill_data)
  );

endmodule

// File: rtl/rpmc_checker.sv
module rpmc_checker #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              victim_dirty,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [LINE_W-1:0] mem_wr_data,
  input logic              mem_wr_ack,
  input logic              cpu_restart,
  input logic              copy_evt,
  input logic              buf_full
);

  a_r11_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));

  a_r9_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && mem_wr_ack |=> !buf_full);

  a_r5_restart_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_ack |=> cpu_restart);

  a_r5_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_restart |=> !cpu_restart);

  a_r3_copy_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |=> mem_rd_req && buf_full);

  a_r2_clean_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready && !victim_dirty |=> mem_rd_req && mem_rd_addr == $past(miss_addr));

  a_r7_conflict_stall: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && buf_full && miss_addr == mem_wr_addr |-> !miss_ready);

  a_r8_dirty_stall: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && victim_dirty && buf_full |-> !miss_ready);

  a_r4_wb_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> buf_full && !cpu_restart);

endmodule

bind rd_prio_miss_ctrl rpmc_checker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_valid   (miss_valid),
  .miss_ready   (miss_ready),
  .victim_dirty (victim_dirty),
  .miss_addr    (miss_addr),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_ack   (mem_rd_ack),
  .mem_wr_req   (mem_wr_req),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_ack   (mem_wr_ack),
  .cpu_restart  (cpu_restart),
  .copy_evt     (copy_evt),
  .buf_full     (buf_full)
);

// File: tb/rd_prio_miss_ctrl_test.sv
module rd_prio_miss_ctrl_test;
  localparam int AW = 16;
  localparam int LW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [AW-1:0] miss_addr = '0;
  logic          victim_dirty = 1'b0;
  logic [AW-1:0] victim_addr = '0;
  logic [LW-1:0] victim_data = '0;
  logic          mem_rd_req;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rd_ack = 1'b0;
  logic [LW-1:0] mem_rd_data = '0;
  logic          mem_wr_req;
  logic [AW-1:0] mem_wr_addr;
  logic [LW-1:0] mem_wr_data;
  logic          mem_wr_ack = 1'b0;
  logic          cpu_restart;
  logic [LW-1:0] cpu_fill_data;

  always #4 clk = ~clk;

  rd_prio_miss_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .victim_dirty(victim_dirty), .victim_addr(victim_addr), .victim_data(victim_data),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .cpu_restart(cpu_restart), .cpu_fill_data(cpu_fill_data)
  );

  int vectors = 0;
  int misses  = 0;
  int rd_lat = 1, wr_lat = 1, rd_wait = 0, wr_wait = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [LW-1:0] mem_line(input logic [AW-1:0] a);
    return {8{a ^ 16'h5A5A}};
  endfunction
  function automatic logic [LW-1:0] dirty_line(input logic [AW-1:0] a);
    return {8{a + 16'h1111}};
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: state as an integer, parked line as queues.
  int            m_st = 0;   // 0 idle, 1 copy, 2 read, 3 restart, 4 writeback
  logic [AW-1:0] m_addr = '0;
  logic [AW-1:0] m_sa = '0;
  logic [LW-1:0] m_sd = '0;
  logic [LW-1:0] m_fill = '0;
  logic [AW-1:0] q_a[$];
  logic [LW-1:0] q_d[$];

  function automatic logic exp_ready();
    if (m_st != 0) return 1'b0;
    if (q_a.size() != 0 && (victim_dirty || miss_addr == q_a[0])) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_addr = '0; m_fill = '0; q_a.delete(); q_d.delete();
    end else begin
      case (m_st)
        0: if (miss_valid && exp_ready()) begin
             m_addr = miss_addr;
             if (victim_dirty) begin m_sa = victim_addr; m_sd = victim_data; m_st = 1; end
             else m_st = 2;
           end else if (q_a.size() != 0) m_st = 4;
        1: begin q_a.push_back(m_sa); q_d.push_back(m_sd); m_st = 2; end
        2: if (mem_rd_ack) begin m_fill = mem_rd_data; m_st = 3; end
        3: m_st = 0;
        4: if (mem_wr_ack) begin void'(q_a.pop_front()); void'(q_d.pop_front()); m_st = 0; end
        default: m_st = 0;
      endcase
    end
  end

  // Memory responder with adjustable latency.
  always @(negedge clk) begin
    if (mem_rd_req && !mem_rd_ack) begin
      if (rd_wait == 0) begin mem_rd_ack = 1'b1; mem_rd_data = mem_line(mem_rd_addr); end
      else rd_wait--;
    end else begin mem_rd_ack = 1'b0; rd_wait = rd_lat; end
    if (mem_wr_req && !mem_wr_ack) begin
      if (wr_wait == 0) mem_wr_ack = 1'b1;
      else wr_wait--;
    end else begin mem_wr_ack = 1'b0; wr_wait = wr_lat; end
  end

  // Per-cycle comparison, sampled mid-cycle.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(miss_ready == exp_ready(), "R7 R8 miss_ready", LW'(miss_ready), LW'(exp_ready()));
      chk(mem_rd_req == (m_st == 2), "R2 R3 R6 mem_rd_req", LW'(mem_rd_req), LW'(m_st == 2));
      if (m_st == 2) chk(mem_rd_addr == m_addr, "R10 mem_rd_addr", LW'(mem_rd_addr), LW'(m_addr));
      chk(mem_wr_req == (m_st == 4), "R4 R6 mem_wr_req", LW'(mem_wr_req), LW'(m_st == 4));
      if (m_st == 4 && q_a.size() != 0) begin
        chk(mem_wr_addr == q_a[0], "R9 mem_wr_addr", LW'(mem_wr_addr), LW'(q_a[0]));
        chk(mem_wr_data == q_d[0], "R9 mem_wr_data", mem_wr_data, q_d[0]);
      end
      chk(cpu_restart == (m_st == 3), "R5 cpu_restart", LW'(cpu_restart), LW'(m_st == 3));
      if (m_st == 3) chk(cpu_fill_data == m_fill, "R5 cpu_fill_data", cpu_fill_data, m_fill);
      chk(!(mem_rd_req && mem_wr_req), "R11 one channel", LW'({mem_rd_req, mem_wr_req}), LW'(0));
    end
  end

  task automatic issue(input logic [AW-1:0] a, input logic d,
                       input logic [AW-1:0] va);
    logic acc;
    miss_valid = 1'b1; miss_addr = a; victim_dirty = d;
    victim_addr = va; victim_data = dirty_line(va);
    forever begin
      #2 acc = miss_ready;
      @(negedge clk);
      if (acc) break;
    end
    miss_valid = 1'b0; victim_dirty = 1'b0;
  endtask

  task automatic settle();
    repeat (25) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    chk(miss_ready && !mem_rd_req && !mem_wr_req && !cpu_restart, "R1 reset outputs",
        LW'({miss_ready, mem_rd_req, mem_wr_req, cpu_restart}), LW'(4'b1000));
    @(negedge clk);
    // R2 clean miss
    issue(16'h0100, 1'b0, 16'h0000);
    settle();
    // R3 R4 dirty miss, read first then writeback
    issue(16'h0200, 1'b1, 16'h0300);
    settle();
    // R6 non-conflicting clean miss while a line is parked
    wr_lat = 3;
    issue(16'h0400, 1'b1, 16'h0500);
    issue(16'h0600, 1'b0, 16'h0000);
    settle();
    // R7 miss to the parked address
    issue(16'h0700, 1'b1, 16'h0800);
    issue(16'h0800, 1'b0, 16'h0000);
    settle();
    // R8 second dirty eviction
    issue(16'h0900, 1'b1, 16'h0A00);
    issue(16'h0B00, 1'b1, 16'h0C00);
    settle();
    // Mixed traffic with varying latencies and frequent conflicts
    for (int i = 0; i < 150; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_lat = int'(lfsr[5:4]);
      wr_lat = int'(lfsr[7:6]);
      issue(16'h1000 + {10'd0, lfsr[2:0], 3'd0}, lfsr[3], 16'h1000 + {10'd0, lfsr[10:8], 3'd0});
      if (lfsr[11]) repeat (int'(lfsr[14:12])) @(negedge clk);
    end
    settle();
    finish_run();
  end

endmodule